// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches the write traffic that a host sends into the boot-buffer address window of a flash device and turns it into device actions. Three commands are understood. The first requests a warm reset. The second is a two-write page load: an arming opcode is followed by a confirming write, and the block then asks an external array interface for one page. The third is identification: the block writes the manufacturer code, the device code and the write-protection status into the first three words of the boot buffer.

The block keeps its own page-address register. Each page load presents the current block address, sampled at the confirming write, together with the stored page address. The request is a single-cycle pulse. When the array interface acknowledges it, the page address moves forward by four and wraps within eight bits. Array timing and buffer storage are outside the block. The boot buffer is reached through a plain registered write port, so a block RAM can sit behind it.

Top module: `bootcmd_seq`

## Requirements
- R1: Only writes at word addresses 0x0000 to 0x01FF and 0x8000 to 0x800F are decoded. A write anywhere else changes no output and no state.
- R2: A write of 0x00F0, with no load armed, raises `warm_rst_req` for exactly the cycle after the write. It also clears the page register to 0 and abandons any load still waiting for acknowledge.
- R3: A write of 0x00E0 arms a pending load. The next accepted write clears the pending state and is never decoded as a command.
- R4: A confirming write of 0x0000 while armed raises `ld_req` for one cycle, in the cycle after the write. `ld_blk` carries `blk_addr` as sampled at the write, and `ld_page` carries the stored page address.
- R5: The page register is 0 after reset. Each `ld_ack` received while a request is outstanding adds 4 to it, modulo 256.
- R6: A confirming write with any nonzero value only clears the pending state. It raises no request, no reset, no boot-buffer write and no error flag.
- R7: A write of 0x0090, with no load armed, produces three boot-buffer writes in consecutive cycles, starting the cycle after the write. Word 0 receives {8'h00, `id_mfr`}, word 1 receives {8'h00, `id_dev`} and word 2 receives {8'h00, `prot_stat`}, all as sampled at the write.
- R8: `bad_cmd` is sticky. It is set by any other value written while no load is armed, and by a confirming 0x0000 that arrives while an earlier request still awaits acknowledge; such a confirming write is dropped. Only `rst` clears `bad_cmd`.
- R9: While `rst` (synchronous, active high) is asserted, all outputs go low on the next edge, the pending state is cleared and the page register returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 16 | Host word address |
| wr_data | input | 16 | Host write data |
| id_mfr | input | 8 | Manufacturer code |
| id_dev | input | 8 | Device code |
| prot_stat | input | 8 | Write-protection status |
| blk_addr | input | 16 | Current block address for page loads |
| ld_ack | input | 1 | Array interface accepted the page load |
| bb_we | output | 1 | Boot-buffer write enable |
| bb_addr | output | 8 | Boot-buffer word index |
| bb_data | output | 16 | Boot-buffer write data |
| ld_req | output | 1 | One-cycle page-load request |
| ld_blk | output | 16 | Block address of the request |
| ld_page | output | 8 | Page address of the request |
| warm_rst_req | output | 1 | One-cycle warm-reset request |
| bad_cmd | output | 1 | Sticky unrecognised-command flag |

## Verification
The bench goes after the window edges: 0x01FF and 0x800F must decode, while 0x0200 and 0x8010 must not. A design with an off-by-one window would either fire a reset from outside the window or miss one from inside it. It runs 65 loads in a row to cross the 8-bit wrap. A design that kept a wider page field, or stepped before the acknowledge, would show a wrong `ld_page` on the load after the wrap. It writes command values as the second write of a load sequence, and clears the pending state with `rst`. A design that decoded the second write as a command would raise a reset or an identification sequence where none belongs. It confirms a load while the first is still unacknowledged; a design that queued or re-issued that request would emit a second pulse instead of flagging an error.

// File: rtl/bootcmd_pkg.sv
package bootcmd_pkg;
  localparam int CMD_W = 16;

  localparam logic [CMD_W-1:0] OP_WARM_RST = 16'h00F0;
  localparam logic [CMD_W-1:0] OP_LOAD_ARM = 16'h00E0;
  localparam logic [CMD_W-1:0] OP_IDENT    = 16'h0090;
  localparam logic [CMD_W-1:0] OP_LOAD_GO  = 16'h0000;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_RST,
    CMD_ARM,
    CMD_IDENT,
    CMD_LOAD,
    CMD_SKIP,
    CMD_BAD
  } cmd_e;
endpackage

// File: rtl/bootcmd_decode.sv
module bootcmd_decode
  import bootcmd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LO_WORDS = 512,
  parameter int HI_BASE  = 32'h8000,
  parameter int HI_WORDS = 16
) (
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [CMD_W-1:0] wr_data_i,
  input  logic             pend_i,
  output cmd_e             cmd_o
);
  localparam logic [AW:0] LO_END = (AW+1)'(LO_WORDS);
  localparam logic [AW:0] HI_BEG = (AW+1)'(HI_BASE);
  localparam logic [AW:0] HI_END = (AW+1)'(HI_BASE + HI_WORDS);

  logic [AW:0] addr_x;
  logic        hit;

  always_comb begin
    addr_x = {1'b0, wr_addr_i};
    hit    = wr_en_i && ((addr_x < LO_END) || ((addr_x >= HI_BEG) && (addr_x < HI_END)));
    cmd_o  = CMD_NONE;
    if (hit) begin
      if (pend_i) begin
        cmd_o = (wr_data_i == OP_LOAD_GO) ? CMD_LOAD : CMD_SKIP;
      end else begin
        case (wr_data_i)
          OP_WARM_RST: cmd_o = CMD_RST;
          OP_LOAD_ARM: cmd_o = CMD_ARM;
          OP_IDENT:    cmd_o = CMD_IDENT;
          default:     cmd_o = CMD_BAD;
        endcase
      end
    end
  end
endmodule

// File: rtl/bootcmd_idwr.sv
module bootcmd_idwr
  import bootcmd_pkg::*;
#(
  parameter int BB_AW = 8,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [ID_W-1:0]  mfr_i,
  input  logic [ID_W-1:0]  dev_i,
  input  logic [ID_W-1:0]  wp_i,
  output logic             we_o,
  output logic [BB_AW-1:0] addr_o,
  output logic [CMD_W-1:0] data_o
);
  localparam int          PAD_W = CMD_W - ID_W;
  localparam logic [1:0]  LAST  = 2'd2;

  logic             act_q;
  logic [1:0]       idx_q;
  logic [CMD_W-1:0] data_q;
  logic [ID_W-1:0]  dev_q, wp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
      dev_q  <= '0;
      wp_q   <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      idx_q  <= '0;
      data_q <= {{PAD_W{1'b0}}, mfr_i};
      dev_q  <= dev_i;
      wp_q   <= wp_i;
    end else if (act_q) begin
      if (idx_q == LAST) begin
        act_q <= 1'b0;
      end else begin
        idx_q  <= idx_q + 2'd1;
        data_q <= (idx_q == 2'd0) ? {{PAD_W{1'b0}}, dev_q} : {{PAD_W{1'b0}}, wp_q};
      end
    end
  end

  assign we_o   = act_q;
  assign addr_o = BB_AW'(idx_q);
  assign data_o = data_q;

  // R7: the sequence opens at word 0 in the cycle after the command
  assert_id_first_word_R7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (we_o && addr_o == '0));
  // R7: exactly three words, then the port goes quiet
  assert_id_three_words_R7: assert property (@(posedge clk) disable iff (rst)
    (we_o && addr_o == BB_AW'(LAST) && !start_i) |=> !we_o);
endmodule

// File: rtl/bootcmd_load.sv
module bootcmd_load #(
  parameter int BLK_W     = 16,
  parameter int PAGE_W    = 8,
  parameter int PAGE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              abort_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic [PAGE_W-1:0] page_o,
  output logic              busy_o
);
  localparam logic [PAGE_W-1:0] STEP = PAGE_W'(PAGE_STEP);

  logic              req_q, wait_q;
  logic [BLK_W-1:0]  blk_q;
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      wait_q <= 1'b0;
      blk_q  <= '0;
      page_q <= '0;
    end else begin
      req_q <= go_i;
      if (go_i) blk_q <= blk_i;
      if (abort_i) begin
        wait_q <= 1'b0;
        page_q <= '0;
      end else if (go_i) begin
        wait_q <= 1'b1;
      end else if (ack_i && wait_q) begin
        wait_q <= 1'b0;
        page_q <= page_q + STEP;
      end
    end
  end

  assign req_o  = req_q;
  assign blk_o  = blk_q;
  assign page_o = page_q;
  assign busy_o = wait_q;

  // R4: the request is a single-cycle pulse
  assert_req_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);
  // R4: a request is only shown while it is outstanding
  assert_req_outstanding_R4: assert property (@(posedge clk) disable iff (rst)
    req_o |-> busy_o);
  // R5: the page register moves only on an accepted acknowledge or an abort
  assert_page_moves_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(page_q) |-> ($past(abort_i) || $past(ack_i && wait_q)));
endmodule

// File: rtl/bootcmd_seq.sv
module bootcmd_seq
  import bootcmd_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BB_AW     = 8,
  parameter int ID_W      = 8,
  parameter int BLK_W     = 16,
  parameter int PAGE_W    = 8,
  parameter int PAGE_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [ID_W-1:0]   id_mfr,
  input  logic [ID_W-1:0]   id_dev,
  input  logic [ID_W-1:0]   prot_stat,
  input  logic [BLK_W-1:0]  blk_addr,
  input  logic              ld_ack,
  output logic              bb_we,
  output logic [BB_AW-1:0]  bb_addr,
  output logic [15:0]       bb_data,
  output logic              ld_req,
  output logic [BLK_W-1:0]  ld_blk,
  output logic [PAGE_W-1:0] ld_page,
  output logic              warm_rst_req,
  output logic              bad_cmd
);
  cmd_e cmd;
  logic pend_q, rst_req_q, bad_q, busy;

  bootcmd_decode #(.AW(AW)) u_decode (
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pend_i    (pend_q),
    .cmd_o     (cmd)
  );

  bootcmd_load #(.BLK_W(BLK_W), .PAGE_W(PAGE_W), .PAGE_STEP(PAGE_STEP)) u_load (
    .clk     (clk),
    .rst     (rst),
    .go_i    (cmd == CMD_LOAD && !busy),
    .abort_i (cmd == CMD_RST),
    .blk_i   (blk_addr),
    .ack_i   (ld_ack),
    .req_o   (ld_req),
    .blk_o   (ld_blk),
    .page_o  (ld_page),
    .busy_o  (busy)
  );

  bootcmd_idwr #(.BB_AW(BB_AW), .ID_W(ID_W)) u_idwr (
    .clk     (clk),
    .rst     (rst),
    .start_i (cmd == CMD_IDENT),
    .mfr_i   (id_mfr),
    .dev_i   (id_dev),
    .wp_i    (prot_stat),
    .we_o    (bb_we),
    .addr_o  (bb_addr),
    .data_o  (bb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      rst_req_q <= 1'b0;
      bad_q     <= 1'b0;
    end else begin
      rst_req_q <= (cmd == CMD_RST);
      if (cmd == CMD_ARM) pend_q <= 1'b1;
      else if (cmd == CMD_LOAD || cmd == CMD_SKIP) pend_q <= 1'b0;
      if (cmd == CMD_BAD || (cmd == CMD_LOAD && busy)) bad_q <= 1'b1;
    end
  end

  assign warm_rst_req = rst_req_q;
  assign bad_cmd      = bad_q;

  // R3: any decoded write while armed disarms the sequence
  assert_pend_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && cmd != CMD_NONE) |=> !pend_q);
  // R2: the reset request only follows a warm-reset command
  assert_rst_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(warm_rst_req) |-> ($past(cmd) == CMD_RST));
  // R6: a nonzero second write causes no action
  assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SKIP) |=> (!ld_req && !warm_rst_req && !$rose(bad_cmd)));
  // R8: the error flag holds until reset
  assert_bad_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |=> bad_cmd);
  // R9: reset silences every output
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> (!ld_req && !warm_rst_req && !bb_we && !bad_cmd));
endmodule

// File: tb/test_bootcmd_seq.sv
module test_bootcmd_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  id_mfr = 8'hC3, id_dev = 8'hF0, prot_stat = 8'h04;
  logic [15:0] blk_addr = '0;
  logic        ld_ack = 1'b0;
  logic        bb_we, ld_req, warm_rst_req, bad_cmd;
  logic [7:0]  bb_addr, ld_page;
  logic [15:0] bb_data, ld_blk;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;
  bit  m_pend, m_wait, m_bad;
  logic [7:0] m_page;

  always #(CLK_PERIOD/2) clk = ~clk;

  bootcmd_seq i_bootcmd_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .id_mfr(id_mfr), .id_dev(id_dev), .prot_stat(prot_stat), .blk_addr(blk_addr),
    .ld_ack(ld_ack), .bb_we(bb_we), .bb_addr(bb_addr), .bb_data(bb_data),
    .ld_req(ld_req), .ld_blk(ld_blk), .ld_page(ld_page),
    .warm_rst_req(warm_rst_req), .bad_cmd(bad_cmd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit in_window(input logic [15:0] a);
    return (a < 16'h0200) || (a >= 16'h8000 && a <= 16'h800F);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ld_ack = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_pend = 0; m_wait = 0; m_bad = 0; m_page = '0;
    check(!ld_req && !warm_rst_req && !bb_we && !bad_cmd, "R9 outputs after reset",
          {ld_req, warm_rst_req, bb_we, bad_cmd}, 0);
  endtask

  // one host write followed by checks of every output it may touch
  task automatic op(input logic [15:0] a, input logic [15:0] d, input bit give_ack);
    bit hit, is_load, is_rst, is_id, is_bad, drop;
    logic [7:0] e_mfr, e_dev, e_wp;
    hit = in_window(a);
    is_load = hit && m_pend && d == 16'h0000 && !m_wait;
    drop    = hit && m_pend && d == 16'h0000 && m_wait;
    is_rst  = hit && !m_pend && d == 16'h00F0;
    is_id   = hit && !m_pend && d == 16'h0090;
    is_bad  = hit && !m_pend && !(d inside {16'h00F0, 16'h00E0, 16'h0090});
    e_mfr = id_mfr; e_dev = id_dev; e_wp = prot_stat;
    if (hit) m_pend = !m_pend && d == 16'h00E0;
    if (is_bad || drop) m_bad = 1;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(warm_rst_req == is_rst, "R2 warm reset request", warm_rst_req, is_rst);
    check(ld_req == is_load, "R4 load request", ld_req, is_load);
    check(bad_cmd == m_bad, "R8 error flag", bad_cmd, m_bad);
    if (!hit) check(!bb_we, "R1 outside window ignored", bb_we, 0);
    if (is_rst) begin m_page = '0; m_wait = 0; end
    if (is_load) begin
      check(ld_blk == blk_addr, "R4 request block", ld_blk, blk_addr);
      check(ld_page == m_page, "R5 request page", ld_page, m_page);
      m_wait = 1;
      if (give_ack) begin
        ld_ack = 1'b1;
        @(negedge clk);
        ld_ack = 1'b0;
        check(!ld_req, "R4 single-cycle request", ld_req, 0);
        m_page = m_page + 8'd4;
        m_wait = 0;
      end
    end
    if (is_id) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] eb;
        eb = (k == 0) ? e_mfr : (k == 1) ? e_dev : e_wp;
        check(bb_we && bb_addr == 8'(k) && bb_data == {8'h00, eb}, "R7 identification word",
              {bb_we, bb_addr, bb_data}, {1'b1, 8'(k), 8'h00, eb});
        @(negedge clk);
      end
      check(!bb_we, "R7 sequence ends after word 2", bb_we, 0);
    end else begin
      check(!bb_we, "R6 no boot-buffer write", bb_we, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();

    // R7 identification with distinct bytes
    id_mfr = 8'hA5; id_dev = 8'h3C; prot_stat = 8'h02;
    op(16'h0000, 16'h0090, 1);
    // R4/R5 load through the upper window edge
    blk_addr = 16'h0ABC;
    op(16'h8000, 16'h00E0, 1);
    op(16'h800F, 16'h0000, 1);
    op(16'h0010, 16'h00E0, 1);
    op(16'h0011, 16'h0000, 1);
    // R6 nonzero second write, then a command decoded normally
    op(16'h0001, 16'h00E0, 1);
    op(16'h0002, 16'h00F0, 1);
    op(16'h0003, 16'h0090, 1);
    // R2 warm reset clears the page register
    op(16'h01FF, 16'h00F0, 1);
    op(16'h0000, 16'h00E0, 1);
    op(16'h0000, 16'h0000, 1);
    // R5 wrap of the page register across 64 steps
    for (int i = 0; i < 65; i++) begin
      blk_addr = 16'(i * 7);
      op(16'h8005, 16'h00E0, 1);
      op(16'h8006, 16'h0000, 1);
    end
    // R1 window edges that must be ignored
    op(16'h0200, 16'h00F0, 1);
    op(16'h8010, 16'h0090, 1);
    op(16'h7FFF, 16'h00E0, 1);
    op(16'h0004, 16'h0000, 1);
    // R8 dropped load while an earlier request is unacknowledged
    op(16'h0000, 16'h00E0, 1);
    op(16'h0000, 16'h0000, 0);
    op(16'h0000, 16'h00E0, 1);
    op(16'h0000, 16'h0000, 1);
    op(16'h0000, 16'h00F0, 1);
    // R9 reset clears the flag and a pending arm
    do_reset();
    op(16'h0000, 16'h00E0, 1);
    do_reset();
    op(16'h0000, 16'h00F0, 1);
    // R8 unknown value
    op(16'h0020, 16'h0055, 1);
    do_reset();

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, d;
      int sel;
      sel = $urandom_range(0, 7);
      if (sel == 0) a = 16'($urandom_range(16'h0200, 16'h7FFF));
      else if (sel == 1) a = 16'($urandom_range(16'h8010, 16'hFFFF));
      else if (sel < 5) a = 16'($urandom_range(0, 16'h01FF));
      else a = 16'($urandom_range(16'h8000, 16'h800F));
      sel = $urandom_range(0, 15);
      case (sel)
        0, 1, 2:    d = 16'h00E0;
        3, 4, 5, 6: d = 16'h0000;
        7:          d = 16'h00F0;
        8, 9:       d = 16'h0090;
        10:         d = 16'($urandom);
        default:    d = (i % 50 == 0) ? 16'h0077 : 16'h00E0;
      endcase
      blk_addr  = 16'($urandom);
      id_mfr    = 8'($urandom);
      id_dev    = 8'($urandom);
      prot_stat = 8'($urandom);
      if (i == 200) do_reset();
      op(a, d, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule